// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns one interrupt request into a per-agent delivery mask for a set of processor agents. Each agent has a present flag, an 8-bit physical ID, an 8-bit logical destination and a 4-bit destination model. The per-agent values come in as flattened configuration vectors. A request arrives in one of two ways. The first is an inter-processor command port, which carries a destination byte, a mode bit, a shorthand, a delivery mode, a vector, trigger and level bits, and the index of the requesting agent. The second is a message-signalled write port, which carries a 32-bit address and a 32-bit data word.

The block resolves the destination into a mask over the present agents and registers it. The mask is presented with its delivery mode, vector and trigger as a single-cycle valid pulse. If the request is a de-asserting INIT command, no delivery is made. Instead, a single-cycle arbitration-ID resync pulse goes to the selected agents.

Control is a three-state machine:
- `S_IDLE`: nothing is presented.
- `S_DELIVER`: a resolved delivery is on the outputs.
- `S_RESYNC`: a resync mask is on the outputs.

Transitions are decided each cycle from the accepted request:
- An accepted de-assert command goes to `S_RESYNC`.
- Any other accepted request goes to `S_DELIVER`.
- No request goes to `S_IDLE`.

Every state can move to every state, so back-to-back requests give back-to-back pulses.

Top module: `irq_dest_resolver`

## Requirements
- R1: In physical mode (`cmd_dest_logical`=0, shorthand 0), destination 8'hFF selects every present agent. Any other value selects the present agents whose physical ID equals it, and selects none if no ID matches.
- R2: In logical mode, an agent with model 4'hF (flat) is selected when the destination AND its logical destination is nonzero.
- R3: In logical mode, an agent with model 4'h0 (cluster) is selected when bits 7:4 of the destination and of its logical destination are equal and the AND of bits 3:0 is nonzero. An agent with any other model is never selected logically.
- R4: The shorthand works as follows, and any nonzero shorthand ignores the destination field:
  - 0 uses the destination field.
  - 1 selects the requester only.
  - 2 selects all agents.
  - 3 selects all agents except the requester.
- R5: With delivery mode 3'b001 (lowest priority), the mask is reduced to its lowest-indexed set bit.
- R6: A command with delivery mode 3'b101 (INIT), level 0 and trigger 1 gives no `out_valid`. Instead, `out_resync` carries the selected mask for one cycle. INIT with any other level/trigger pair delivers normally.
- R7: For a message-signalled write, the fields come from fixed positions and the shorthand is taken as 0:
  - destination from address bits 19:12
  - logical mode from address bit 2
  - vector from data bits 7:0
  - delivery mode from data bits 10:8
  - trigger from data bit 15
- R8: After reset, `out_valid`, `out_mask` and `out_resync` are zero. A request accepted at a clock edge is presented for exactly one cycle after that edge.
- R9: When both ports are valid in one cycle, the command is taken and the message-signalled write is dropped.
- R10: An agent whose present flag is clear is never in `out_mask` or `out_resync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| agent_present | input | N_AGENTS | Agent exists |
| agent_phys_id | input | 8*N_AGENTS | Physical IDs, agent i at bits 8i+7:8i |
| agent_log_dest | input | 8*N_AGENTS | Logical destinations |
| agent_model | input | 4*N_AGENTS | Destination models, agent i at bits 4i+3:4i |
| cmd_valid | input | 1 | Command request |
| cmd_dest | input | 8 | Destination byte |
| cmd_dest_logical | input | 1 | 1 = logical mode |
| cmd_shorthand | input | 2 | Destination shorthand |
| cmd_dmode | input | 3 | Delivery mode |
| cmd_vector | input | 8 | Vector |
| cmd_trigger | input | 1 | 1 = level trigger |
| cmd_level | input | 1 | Level bit |
| cmd_requester | input | IDX_W | Requesting agent index |
| msg_valid | input | 1 | Message-signalled write |
| msg_addr | input | 32 | Write address |
| msg_data | input | 32 | Write data |
| out_valid | output | 1 | Delivery pulse |
| out_mask | output | N_AGENTS | Target agents |
| out_dmode | output | 3 | Delivery mode |
| out_vector | output | 8 | Vector |
| out_trigger | output | 1 | Trigger |
| out_resync | output | N_AGENTS | Arbitration-ID resync pulse per agent |

## Verification
The hardest case to reach from the ports is a logical destination that mixes flat and cluster agents in one request, while one of the matching agents is absent. Here every matching rule and the present filter must act together on a single mask. The bench sets up four flat agents and two clusters, with the last agent of the second cluster left absent. It then picks destination bytes whose bits hit agents of several kinds at once. Colliding requests and de-assert INIT commands are issued on consecutive cycles. This checks that port priority and the resync path do not leak into the neighbouring pulse.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
    typedef enum logic [2:0] {
        DM_FIXED    = 3'd0,
        DM_LOWEST   = 3'd1,
        DM_SMI      = 3'd2,
        DM_RSVD     = 3'd3,
        DM_NMI      = 3'd4,
        DM_INIT     = 3'd5,
        DM_STARTUP  = 3'd6,
        DM_EXTERNAL = 3'd7
    } dmode_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_DELIVER = 2'd1,
        S_RESYNC  = 2'd2
    } res_state_e;

    localparam logic [7:0] BCAST_ID      = 8'hFF;
    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;

    localparam int MSG_DEST_LSB  = 12;
    localparam int MSG_LOG_BIT   = 2;
    localparam int MSG_DMODE_LSB = 8;
    localparam int MSG_TRIG_BIT  = 15;
endpackage

// File: rtl/agent_match.sv
module agent_match
    import irq_res_pkg::*;
(
    input  logic [7:0] dest,
    input  logic       logical,
    input  logic [7:0] phys_id,
    input  logic [7:0] log_dest,
    input  logic [3:0] model,
    output logic       hit
);
    logic [7:0] overlap;
    assign overlap = dest & log_dest;

    always_comb begin
        hit = 1'b0;
        if (!logical) begin
            hit = (dest == BCAST_ID) || (dest == phys_id);
        end else if (model == MODEL_FLAT) begin
            hit = (overlap != 8'h00);
        end else if (model == MODEL_CLUSTER) begin
            hit = (dest[7:4] == log_dest[7:4]) && (overlap[3:0] != 4'h0);
        end
    end
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec_in,
    output logic [W-1:0] vec_out
);
    assign vec_out = vec_in & (~vec_in + W'(1));
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
    import irq_res_pkg::*;
#(
    parameter int N_AGENTS = 8,
    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_AGENTS-1:0]   agent_present,
    input  logic [8*N_AGENTS-1:0] agent_phys_id,
    input  logic [8*N_AGENTS-1:0] agent_log_dest,
    input  logic [4*N_AGENTS-1:0] agent_model,
    input  logic                  cmd_valid,
    input  logic [7:0]            cmd_dest,
    input  logic                  cmd_dest_logical,
    input  logic [1:0]            cmd_shorthand,
    input  logic [2:0]            cmd_dmode,
    input  logic [7:0]            cmd_vector,
    input  logic                  cmd_trigger,
    input  logic                  cmd_level,
    input  logic [IDX_W-1:0]      cmd_requester,
    input  logic                  msg_valid,
    input  logic [31:0]           msg_addr,
    input  logic [31:0]           msg_data,
    output logic                  out_valid,
    output logic [N_AGENTS-1:0]   out_mask,
    output logic [2:0]            out_dmode,
    output logic [7:0]            out_vector,
    output logic                  out_trigger,
    output logic [N_AGENTS-1:0]   out_resync
);
    // Selected request fields (command wins over message, R9)
    logic [7:0] sel_dest;
    logic       sel_logical;
    logic [1:0] sel_shorthand;
    logic [2:0] sel_dmode;
    logic [7:0] sel_vector;
    logic       sel_trigger;
    logic       sel_deassert;
    logic       accept;

    logic unused_msg_bits;
    assign unused_msg_bits = ^{msg_addr[31:20], msg_addr[11:3], msg_addr[1:0],
                               msg_data[31:16], msg_data[14:11]};

    always_comb begin
        accept = cmd_valid || msg_valid;
        if (cmd_valid) begin
            sel_dest      = cmd_dest;
            sel_logical   = cmd_dest_logical;
            sel_shorthand = cmd_shorthand;
            sel_dmode     = cmd_dmode;
            sel_vector    = cmd_vector;
            sel_trigger   = cmd_trigger;
            sel_deassert  = (cmd_dmode == DM_INIT) && !cmd_level && cmd_trigger;
        end else begin
            sel_dest      = msg_addr[MSG_DEST_LSB +: 8];
            sel_logical   = msg_addr[MSG_LOG_BIT];
            sel_shorthand = 2'd0;
            sel_dmode     = msg_data[MSG_DMODE_LSB +: 3];
            sel_vector    = msg_data[7:0];
            sel_trigger   = msg_data[MSG_TRIG_BIT];
            sel_deassert  = 1'b0;
        end
    end

    // Per-agent destination match and shorthand masks
    logic [N_AGENTS-1:0] hit_vec;
    logic [N_AGENTS-1:0] self_vec;

    for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
        agent_match u_match (
            .dest     (sel_dest),
            .logical  (sel_logical),
            .phys_id  (agent_phys_id[8*i +: 8]),
            .log_dest (agent_log_dest[8*i +: 8]),
            .model    (agent_model[4*i +: 4]),
            .hit      (hit_vec[i])
        );
        assign self_vec[i] = (cmd_requester == IDX_W'(i));
    end

    logic [N_AGENTS-1:0] base_mask;
    logic [N_AGENTS-1:0] low_mask;
    logic [N_AGENTS-1:0] final_mask;

    always_comb begin
        unique case (sel_shorthand)
            2'd0: base_mask = hit_vec;
            2'd1: base_mask = self_vec;
            2'd2: base_mask = '1;
            2'd3: base_mask = ~self_vec;
            default: base_mask = '0;
        endcase
        base_mask = base_mask & agent_present;
    end

    lowest_pick #(.W(N_AGENTS)) u_pick (
        .vec_in  (base_mask),
        .vec_out (low_mask)
    );

    assign final_mask = (sel_dmode == DM_LOWEST) ? low_mask : base_mask;

    // State machine: state register
    res_state_e state_q, state_d;

    always_comb begin
        if (!accept)           state_d = S_IDLE;
        else if (sel_deassert) state_d = S_RESYNC;
        else                   state_d = S_DELIVER;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output payload registers
    logic [N_AGENTS-1:0] mask_q;
    logic [2:0]          dmode_q;
    logic [7:0]          vector_q;
    logic                trigger_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '0;
            dmode_q   <= 3'd0;
            vector_q  <= 8'd0;
            trigger_q <= 1'b0;
        end else if (accept) begin
            mask_q    <= final_mask;
            dmode_q   <= sel_dmode;
            vector_q  <= sel_vector;
            trigger_q <= sel_trigger;
        end
    end

    always_comb begin
        out_valid   = 1'b0;
        out_mask    = '0;
        out_resync  = '0;
        out_dmode   = dmode_q;
        out_vector  = vector_q;
        out_trigger = trigger_q;
        unique case (state_q)
            S_IDLE:    ;
            S_DELIVER: begin
                out_valid = 1'b1;
                out_mask  = mask_q;
            end
            S_RESYNC:  out_resync = mask_q;
            default:   ;
        endcase
    end

    // Assertions
    a_r10_absent_never_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || (out_resync != '0)) |->
            (((out_mask | out_resync) & ~$past(agent_present)) == '0));

    a_r5_lowest_single: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dmode == DM_LOWEST) |-> $onehot0(out_mask));

    a_r6_resync_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_resync != '0) |-> (!out_valid && out_dmode == DM_INIT));

    a_r8_pulse_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(cmd_valid || msg_valid));

    a_r9_cmd_priority: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid && msg_valid) |-> (out_vector == $past(cmd_vector)));

    a_r4_self_only: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cmd_valid && cmd_shorthand == 2'd1)) |->
            ($countones(out_mask) <= 1));
endmodule

// File: tb/sim_irq_dest_resolver.sv
module sim_irq_dest_resolver;
    localparam int N = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   agent_present;
    logic [8*N-1:0] agent_phys_id;
    logic [8*N-1:0] agent_log_dest;
    logic [4*N-1:0] agent_model;
    logic           cmd_valid = 1'b0;
    logic [7:0]     cmd_dest = '0;
    logic           cmd_dest_logical = 1'b0;
    logic [1:0]     cmd_shorthand = '0;
    logic [2:0]     cmd_dmode = '0;
    logic [7:0]     cmd_vector = '0;
    logic           cmd_trigger = 1'b0;
    logic           cmd_level = 1'b0;
    logic [IW-1:0]  cmd_requester = '0;
    logic           msg_valid = 1'b0;
    logic [31:0]    msg_addr = '0;
    logic [31:0]    msg_data = '0;
    logic           out_valid;
    logic [N-1:0]   out_mask;
    logic [2:0]     out_dmode;
    logic [7:0]     out_vector;
    logic           out_trigger;
    logic [N-1:0]   out_resync;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irq_dest_resolver #(.N_AGENTS(N)) u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_cmd(logic [7:0] d, logic lg, logic [1:0] sh, logic [2:0] dm,
                            logic [7:0] vec, logic trg, logic lvl, logic [IW-1:0] rq);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_dest = d; cmd_dest_logical = lg; cmd_shorthand = sh;
        cmd_dmode = dm; cmd_vector = vec; cmd_trigger = trg; cmd_level = lvl;
        cmd_requester = rq;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_msg(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        msg_valid = 1'b1; msg_addr = a; msg_data = d;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic expect_delivery(string req, logic [N-1:0] m);
        check(req, {31'd0, out_valid}, 32'd1);
        check(req, {24'd0, out_mask}, {24'd0, m});
    endtask

    task automatic t_reset;
        check("R8 reset valid", {31'd0, out_valid}, 32'd0);
        check("R8 reset mask", {24'd0, out_mask | out_resync}, 32'd0);
    endtask

    task automatic t_physical;
        send_cmd(8'hFF, 0, 0, 3'd0, 8'h30, 0, 0, 0); expect_delivery("R1 broadcast", 8'h7F);
        check("R8 vector", {24'd0, out_vector}, 32'h30);
        @(negedge clk); check("R8 single pulse", {31'd0, out_valid}, 32'd0);
        send_cmd(8'h13, 0, 0, 3'd0, 8'h31, 0, 0, 0); expect_delivery("R1 id match", 8'h08);
        send_cmd(8'h55, 0, 0, 3'd0, 8'h32, 0, 0, 0); expect_delivery("R1 no match", 8'h00);
        send_cmd(8'h17, 0, 0, 3'd0, 8'h33, 0, 0, 0); expect_delivery("R10 absent id", 8'h00);
    endtask

    task automatic t_logical;
        send_cmd(8'h05, 1, 0, 3'd0, 8'h40, 0, 0, 0); expect_delivery("R2 flat", 8'h05);
        send_cmd(8'h23, 1, 0, 3'd0, 8'h41, 0, 0, 0); expect_delivery("R3 cluster+flat", 8'h33);
        send_cmd(8'h32, 1, 0, 3'd0, 8'h42, 0, 0, 0); expect_delivery("R10 cluster absent", 8'h02);
        agent_model[3:0] = 4'h5;
        send_cmd(8'h01, 1, 0, 3'd0, 8'h43, 0, 0, 0); expect_delivery("R3 other model", 8'h00);
        agent_model[3:0] = 4'hF;
    endtask

    task automatic t_shorthand;
        send_cmd(8'h10, 0, 2'd1, 3'd0, 8'h50, 0, 0, 3); expect_delivery("R4 self", 8'h08);
        send_cmd(8'h10, 0, 2'd2, 3'd0, 8'h51, 0, 0, 3); expect_delivery("R4 all", 8'h7F);
        send_cmd(8'h10, 0, 2'd3, 3'd0, 8'h52, 0, 0, 0); expect_delivery("R4 all but self", 8'h7E);
        send_cmd(8'h10, 0, 2'd1, 3'd0, 8'h53, 0, 0, 7); expect_delivery("R10 absent self", 8'h00);
    endtask

    task automatic t_lowest;
        send_cmd(8'h00, 0, 2'd3, 3'd1, 8'h60, 0, 0, 0); expect_delivery("R5 lowest shorthand", 8'h02);
        send_cmd(8'h23, 1, 0, 3'd1, 8'h61, 0, 0, 0); expect_delivery("R5 lowest logical", 8'h01);
        check("R5 dmode", {29'd0, out_dmode}, 32'd1);
    endtask

    task automatic t_init;
        send_cmd(8'hFF, 0, 0, 3'd5, 8'h00, 1, 0, 0);
        check("R6 no valid", {31'd0, out_valid}, 32'd0);
        check("R6 resync", {24'd0, out_resync}, 32'h7F);
        @(negedge clk); check("R6 resync one cycle", {24'd0, out_resync}, 32'd0);
        send_cmd(8'h11, 0, 0, 3'd5, 8'h00, 0, 1, 0); expect_delivery("R6 assert init", 8'h02);
        check("R6 assert no resync", {24'd0, out_resync}, 32'd0);
    endtask

    task automatic t_msg;
        send_msg(32'hFEE1_3000, 32'h0000_8041); expect_delivery("R7 physical", 8'h08);
        check("R7 vector", {24'd0, out_vector}, 32'h41);
        check("R7 trigger", {31'd0, out_trigger}, 32'd1);
        check("R7 dmode", {29'd0, out_dmode}, 32'd0);
        send_msg(32'hFEE2_3004, 32'h0000_0155); expect_delivery("R7 logical lowest", 8'h01);
        check("R7 dmode lowest", {29'd0, out_dmode}, 32'd1);
        check("R7 trigger clear", {31'd0, out_trigger}, 32'd0);
    endtask

    task automatic t_priority;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_dest = 8'h10; cmd_dest_logical = 0; cmd_shorthand = 0;
        cmd_dmode = 3'd0; cmd_vector = 8'h11; cmd_trigger = 0; cmd_level = 0;
        msg_valid = 1'b1; msg_addr = 32'hFEE1_3000; msg_data = 32'h0000_0022;
        @(negedge clk);
        cmd_valid = 1'b0; msg_valid = 1'b0;
        expect_delivery("R9 cmd wins", 8'h01);
        check("R9 cmd vector", {24'd0, out_vector}, 32'h11);
        @(negedge clk); check("R9 msg dropped", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_dest = 8'h12; cmd_dest_logical = 0; cmd_shorthand = 0;
        cmd_dmode = 3'd0; cmd_vector = 8'h70;
        @(negedge clk);
        cmd_dest = 8'hFF; cmd_dmode = 3'd5; cmd_trigger = 1; cmd_level = 0;
        expect_delivery("R8 first pulse", 8'h04);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_trigger = 0;
        check("R8 then resync", {24'd0, out_resync}, 32'h7F);
        check("R6 resync no valid", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        agent_present = 8'h7F;
        for (int i = 0; i < 4; i++) begin
            agent_phys_id[8*i +: 8]  = 8'h10 + 8'(i);
            agent_log_dest[8*i +: 8] = 8'(1 << i);
            agent_model[4*i +: 4]    = 4'hF;
        end
        for (int i = 4; i < 8; i++) begin
            agent_phys_id[8*i +: 8]  = 8'h10 + 8'(i);
            agent_model[4*i +: 4]    = 4'h0;
        end
        agent_log_dest[8*4 +: 8] = 8'h21;
        agent_log_dest[8*5 +: 8] = 8'h22;
        agent_log_dest[8*6 +: 8] = 8'h31;
        agent_log_dest[8*7 +: 8] = 8'h32;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_physical();
        t_logical();
        t_shorthand();
        t_lowest();
        t_init();
        t_msg();
        t_priority();
        t_back_to_back();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule